// File: doc/BRIEF.md
# CAN Controller Configuration-State Sequencer

This block governs when a CAN protocol controller is in its configuration state and when it may take part in bus traffic. It keeps two control flags: a configuration-hold flag, which takes the controller off the bus, and a change-enable flag. Together these two flags unlock the bit-timing registers. While the hold flag is set, the block forces the transmit line recessive and keeps the protocol engine out of bus activity.

Firmware sets the hold flag and the change-enable flag, writes the bit-timing word and its prescaler extension, and then clears the hold flag. Once the hold flag is clear, the block watches the receive bit that the bit-timing logic samples at each sample point. It lets the protocol engine join only after it has seen a run of consecutive recessive bits long enough to mark an idle bus. A bus-off event from the error logic puts the controller back into the hold state by itself. Only firmware can release it.

Top module: `can_init_seq`

## Requirements
- R1: After a synchronous active-low reset, the hold flag is 1 and the change-enable flag is 0. `tx_force_rec` is 1, `bus_join` is 0, `timing_q` equals `TIMING_RST` (default 16'h2301) and `tx_ext_q` equals `EXT_RST` (default 0).
- R2: The hold flag is set by a control write (address 0) with data bit 0 = 1, and by a one-cycle `bus_off_evt`. When a bus-off event and a control write that clears the flag arrive in the same cycle, the bus-off event wins.
- R3: While the hold flag is 1, `tx_force_rec` is 1 and `bus_join` is 0, whatever the receive samples are.
- R4: Setting the hold flag, by firmware or by bus-off, leaves `timing_q` and `tx_ext_q` unchanged.
- R5: A write to the timing register (address 1, data bits 15:0) or to the extension register (address 2, data bits 3:0) is taken only when the hold flag and the change-enable flag (control data bit 1) are both 1 before the write. In every other case it is ignored. A write to address 3 has no effect.
- R6: Only a control write with data bit 0 = 0 clears the hold flag. A bus-off event never clears it. Once the flag is clear, `tx_force_rec` is 0 from the cycle after that write.
- R7: Once the hold flag is clear, `bus_join` becomes 1 in the cycle after the 11th consecutive strobed recessive sample, and not before.
- R8: A strobed dominant sample (`rx_bit` = 0) that arrives before `bus_join` is 1 restarts the count. A further 11 recessive samples are then needed.
- R9: `rx_bit` is ignored in cycles where `sample_stb` is 0. The count advances by at most one per strobe.
- R10: If the hold flag is set again while the block waits for an idle bus, the partial count is discarded. After the next release, a full 11 recessive samples are needed.
- R11: `bus_join` falls in the same cycle that `tx_force_rec` rises.
- R12: Once `bus_join` is 1, strobed dominant samples leave it at 1 until the hold flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | CPU register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 timing, 2 extension |
| wr_data | input | 16 | Write data |
| bus_off_evt | input | 1 | One-cycle pulse when the controller enters bus-off |
| sample_stb | input | 1 | One-cycle strobe at each bit sample point |
| rx_bit | input | 1 | Sampled receive bit, 1 = recessive |
| tx_force_rec | output | 1 | 1 forces the transmit line recessive (hold flag) |
| bus_join | output | 1 | 1 lets the protocol engine take part in bus traffic |
| timing_q | output | 16 | Bit-timing register contents |
| tx_ext_q | output | 4 | Prescaler extension register contents |

## Verification
The hardest state to reach is a partial idle count that is then cut short. It is cut short either by a dominant bit at each possible position in the run, or by the hold flag being set again mid-run. Either way, the bench must then show that the full 11 samples are needed after that point. The bench sweeps the position of the dominant break from 0 to 10 and the strobe spacing from 1 to 3 cycles. During the gaps between strobes it drives dominant bits without a strobe. It also walks all four combinations of the two flags before a timing write, and checks that each write lands or is dropped.

// File: rtl/can_init_pkg.sv
// Package: register addresses and control bit positions shared by the
// configuration-state sequencer and its bench.
package can_init_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_TIMING = 2'd1,
        REG_EXT    = 2'd2,
        REG_NONE   = 2'd3
    } reg_addr_e;

    localparam int CTRL_HOLD_BIT = 0;
    localparam int CTRL_CCE_BIT  = 1;
endpackage

// File: rtl/cis_ctrl.sv
// Module: cis_ctrl
// Holds the configuration-hold flag and the change-enable flag.
// Assumes: wr_sel is an address-decoded write strobe, and bus_off is a single-cycle pulse.
// Hardware may only set the hold flag. Only a firmware write clears it.
module cis_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_sel,
    input  logic [1:0] wr_bits,
    input  logic       bus_off,
    output logic       hold_o,
    output logic       cce_o
);
    import can_init_pkg::*;

    logic hold_q;
    logic cce_q;

    // Update both flags; bus-off takes priority over a firmware clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b1;
            cce_q  <= 1'b0;
        end else begin
            if (wr_sel) begin
                cce_q  <= wr_bits[CTRL_CCE_BIT];
                hold_q <= wr_bits[CTRL_HOLD_BIT] | bus_off;
            end else if (bus_off) begin
                hold_q <= 1'b1;
            end
        end
    end

    assign hold_o = hold_q;
    assign cce_o  = cce_q;

    AST_HOLD_CLEARED_BY_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_q) |-> $past(wr_sel && !wr_bits[CTRL_HOLD_BIT] && !bus_off)); // R6

    AST_BUS_OFF_SETS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off |=> hold_q); // R2
endmodule

// File: rtl/cis_cfg_reg.sv
// Module: cis_cfg_reg
// A single bit-timing configuration register that loads only while unlocked.
// Assumes: wr_sel is already decoded for this register's address, and unlock
// reflects the control flags as they stand before the write.
module cis_cfg_reg #(
    parameter int               WIDTH   = 16,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic             unlock,
    input  logic [WIDTH-1:0] wr_val,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] q;

    // Load the new value only on an unlocked write to this register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (wr_sel && unlock) begin
            q <= wr_val;
        end
    end

    assign q_o = q;

    AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock |=> $stable(q)); // R5
    AST_UNSELECTED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(q)); // R4
endmodule

// File: rtl/cis_idle_detect.sv
// Module: cis_idle_detect
// Counts consecutive recessive samples after the hold flag is released. It
// grants bus participation once IDLE_BITS recessive bits have been seen in a row.
// Assumes: sample_stb pulses once per bit time, and rx_bit is 1 for recessive.
module cis_idle_detect #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic sample_stb,
    input  logic rx_bit,
    output logic join_o
);
    localparam int CNT_W = $clog2(IDLE_BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(IDLE_BITS);

    logic [CNT_W-1:0] cnt;
    logic             join_q;

    // Run the recessive-bit counter; hold or reset clears both count and grant.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) begin
            cnt    <= '0;
            join_q <= 1'b0;
        end else if (!join_q && sample_stb) begin
            if (!rx_bit) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    join_q <= 1'b1;
                end
            end
        end
    end

    // Grant falls in the same cycle the hold flag rises.
    assign join_o = join_q & ~hold_i;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL); // R7
    AST_JOIN_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(join_q) |-> $past(sample_stb && rx_bit && !hold_i)); // R9
    AST_DOMINANT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !join_q && sample_stb && !rx_bit) |=> (cnt == '0)); // R8
    AST_HOLD_DROPS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (!join_q && cnt == '0)); // R10
    AST_JOIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (join_q && !hold_i) |=> join_q); // R12
endmodule

// File: rtl/can_init_seq.sv
// Module: can_init_seq (top)
// Sequences entry into and exit from a CAN controller's configuration state.
// It decodes CPU register writes, gates the timing registers on both control
// flags, forces TX recessive while holding, and gates bus participation on idle detection.
// Assumes: all inputs are synchronous to clk.
module can_init_seq #(
    parameter int                  TIMING_W   = 16,
    parameter int                  EXT_W      = 4,
    parameter int                  IDLE_BITS  = 11,
    parameter logic [TIMING_W-1:0] TIMING_RST = 16'h2301,
    parameter logic [EXT_W-1:0]    EXT_RST    = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [TIMING_W-1:0] wr_data,
    input  logic                bus_off_evt,
    input  logic                sample_stb,
    input  logic                rx_bit,
    output logic                tx_force_rec,
    output logic                bus_join,
    output logic [TIMING_W-1:0] timing_q,
    output logic [EXT_W-1:0]    tx_ext_q
);
    import can_init_pkg::*;

    logic sel_ctrl;
    logic sel_timing;
    logic sel_ext;
    logic hold;
    logic cce;
    logic unlock;

    // Decode the write address into per-register strobes.
    always_comb begin
        sel_ctrl   = wr_en && (wr_addr == REG_CTRL);
        sel_timing = wr_en && (wr_addr == REG_TIMING);
        sel_ext    = wr_en && (wr_addr == REG_EXT);
    end

    assign unlock = hold & cce;

    cis_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (sel_ctrl),
        .wr_bits (wr_data[1:0]),
        .bus_off (bus_off_evt),
        .hold_o  (hold),
        .cce_o   (cce)
    );

    cis_cfg_reg #(.WIDTH(TIMING_W), .RST_VAL(TIMING_RST)) u_timing (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (sel_timing),
        .unlock (unlock),
        .wr_val (wr_data),
        .q_o    (timing_q)
    );

    cis_cfg_reg #(.WIDTH(EXT_W), .RST_VAL(EXT_RST)) u_ext (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sel (sel_ext),
        .unlock (unlock),
        .wr_val (wr_data[EXT_W-1:0]),
        .q_o    (tx_ext_q)
    );

    cis_idle_detect #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (hold),
        .sample_stb (sample_stb),
        .rx_bit     (rx_bit),
        .join_o     (bus_join)
    );

    assign tx_force_rec = hold;

    AST_JOIN_FALLS_WITH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_force_rec) |-> !bus_join); // R11
    AST_NO_JOIN_WHILE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_force_rec |-> !bus_join); // R3
endmodule

// File: tb/test_can_init_seq.sv
// Bench for can_init_seq. It sweeps flag combinations, break positions and strobe spacings.
module test_can_init_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic        bus_off_evt = 1'b0;
    logic        sample_stb = 1'b0;
    logic        rx_bit = 1'b1;
    logic        tx_force_rec;
    logic        bus_join;
    logic [15:0] timing_q;
    logic [3:0]  tx_ext_q;

    int tests = 0;
    int fails = 0;
    logic [15:0] exp_t = 16'h2301;
    logic [3:0]  exp_e = 4'h0;

    always #2.5 clk = ~clk;

    can_init_seq i_can_init_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bus_off_evt(bus_off_evt), .sample_stb(sample_stb), .rx_bit(rx_bit),
        .tx_force_rec(tx_force_rec), .bus_join(bus_join), .timing_q(timing_q), .tx_ext_q(tx_ext_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic strobe(input logic b);
        sample_stb = 1'b1; rx_bit = b;
        tick();
        sample_stb = 1'b0; rx_bit = 1'b1;
    endtask

    task automatic release_hold();
        wr(2'd0, 16'h0001);
        wr(2'd0, 16'h0000);
    endtask

    initial begin
        #(200000 * 5);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 tx", tx_force_rec, 1);
        chk("R1 join", bus_join, 0);
        chk("R1 timing", timing_q, 16'h2301);
        chk("R1 ext", tx_ext_q, 0);

        // R5 sweep of all flag combinations before a timing write
        for (int m = 0; m < 4; m++) begin
            logic [15:0] v;
            v = 16'h1000 + 16'(m * 16'h0111) + 16'h0005;
            wr(2'd0, 16'h0001);
            wr(2'd0, 16'(m));
            wr(2'd1, v);
            if (m == 3) exp_t = v;
            chk("R5 timing gate", timing_q, exp_t);
            wr(2'd2, v);
            if (m == 3) exp_e = v[3:0];
            chk("R5 ext gate", tx_ext_q, exp_e);
        end
        // R5 address 3 has no effect while unlocked
        wr(2'd0, 16'h0003);
        wr(2'd3, 16'hBEEF);
        chk("R5 addr3 timing", timing_q, exp_t);
        chk("R5 addr3 ext", tx_ext_q, exp_e);

        // R4 setting hold by CPU and by bus-off keeps config
        wr(2'd0, 16'h0002);
        chk("R6 release tx", tx_force_rec, 0);
        wr(2'd0, 16'h0003);
        chk("R4 cpu set timing", timing_q, exp_t);
        chk("R2 cpu set hold", tx_force_rec, 1);
        wr(2'd0, 16'h0000);
        bus_off_evt = 1'b1; tick(); bus_off_evt = 1'b0;
        chk("R2 bus-off sets hold", tx_force_rec, 1);
        chk("R4 bus-off timing", timing_q, exp_t);
        chk("R4 bus-off ext", tx_ext_q, exp_e);

        // R6 bus-off never clears hold; R2 bus-off beats same-cycle clear
        repeat (3) begin bus_off_evt = 1'b1; tick(); end
        bus_off_evt = 1'b0;
        chk("R6 hold kept", tx_force_rec, 1);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0000; bus_off_evt = 1'b1;
        tick();
        wr_en = 1'b0; bus_off_evt = 1'b0;
        chk("R2 bus-off priority", tx_force_rec, 1);

        // R3 recessive run while holding does not grant
        for (int i = 0; i < 14; i++) strobe(1'b1);
        chk("R3 no join in hold", bus_join, 0);
        chk("R3 tx in hold", tx_force_rec, 1);

        // R7 run lengths
        release_hold();
        for (int i = 1; i <= 12; i++) begin
            strobe(1'b1);
            chk("R7 run", bus_join, (i >= 11) ? 1 : 0);
        end

        // R12 dominant samples after grant
        for (int i = 0; i < 3; i++) strobe(1'b0);
        chk("R12 sticky", bus_join, 1);

        // R8 dominant break at each position
        for (int k = 0; k <= 10; k++) begin
            release_hold();
            for (int i = 0; i < k; i++) strobe(1'b1);
            strobe(1'b0);
            for (int i = 1; i <= 11; i++) begin
                strobe(1'b1);
                if (i >= 10) chk("R8 restart", bus_join, (i == 11) ? 1 : 0);
            end
        end

        // R9 strobe spacing with dominant bits in non-strobe cycles
        for (int g = 1; g <= 3; g++) begin
            release_hold();
            for (int i = 1; i <= 11; i++) begin
                for (int j = 1; j < g; j++) begin
                    rx_bit = 1'b0; tick(); rx_bit = 1'b1;
                end
                strobe(1'b1);
                if (i >= 10) chk("R9 spacing", bus_join, (i == 11) ? 1 : 0);
            end
        end

        // R10 hold during wait discards partial count
        release_hold();
        for (int i = 0; i < 6; i++) strobe(1'b1);
        release_hold();
        for (int i = 1; i <= 11; i++) begin
            strobe(1'b1);
            if (i >= 10) chk("R10 full run", bus_join, (i == 11) ? 1 : 0);
        end

        // R11 grant falls with hold set by CPU
        chk("R11 pre join", bus_join, 1);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0001;
        tick();
        wr_en = 1'b0;
        chk("R11 cpu tx", tx_force_rec, 1);
        chk("R11 cpu join", bus_join, 0);

        // R11 grant falls with hold set by bus-off
        wr(2'd0, 16'h0000);
        for (int i = 0; i < 11; i++) strobe(1'b1);
        chk("R11 pre join2", bus_join, 1);
        bus_off_evt = 1'b1; tick(); bus_off_evt = 1'b0;
        chk("R11 bus-off tx", tx_force_rec, 1);
        chk("R11 bus-off join", bus_join, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule